// File: doc/BRIEF.md
# Packet Receive FIFO with Rollback

This block is a circular byte store placed between a packet receiver (the writer) and a CPU (the reader). The receiver pushes bytes one at a time. At the end of each packet it pulses a good or a bad strobe. Bytes of a packet in progress sit behind a start-of-packet marker and are not visible to the CPU. A good packet is committed when the marker moves up to the write pointer. A bad packet is thrown away when the write pointer drops back to the marker, and the retried packet then overwrites the same space.

Committed packets are held as data sets in a two-entry length queue. The CPU is always shown the oldest set: its byte count, an empty flag, and a read port with a one-cycle latency. The CPU can rewind to read the current set again. A release command frees the set and brings the next one forward.

A small control register sets the mode. In single-set mode, which is the reset state, only one committed set may be resident. In dual-set mode two may be resident, so back-to-back packets can be accepted. Two further bits choose whether the end-of-packet strobes commit and roll back on their own, or whether only explicit firmware commands do so.

Top module: `pkt_rx_fifo`

## Requirements
- R1: After reset, ctrl_o reads 3'b111, with bit 0 = single-set mode, bit 1 = automatic commit and bit 2 = automatic rollback. empty_o is 1, full_o is 0, byte_cnt_o is 0 and overflow_o is 0.
- R2: Accepted bytes are returned in write order on rd_data_o, with rd_valid_o high, on the cycle after rd_en_i. Bytes that have not been committed leave empty_o at 1 and byte_cnt_o at 0.
- R3: A commit sets byte_cnt_o to the number of bytes written since the previous commit or rollback. The commit comes from eop_good_i when ctrl bit 1 is set, and from fw_commit_i at any time.
- R4: A rollback discards every byte written since the marker. The rollback comes from eop_bad_i when ctrl bit 2 is set, and from fw_rollback_i at any time. A later commit then contains only the bytes rewritten after it.
- R5: With ctrl bit 1 clear, eop_good_i has no effect. With ctrl bit 2 clear, eop_bad_i has no effect.
- R6: In single-set mode, while one committed set is resident, full_o is 1. A write offered then is dropped, and overflow_o is 1 in the cycle after that write.
- R7: In dual-set mode (ctrl bit 0 clear) two committed sets may be resident. full_o rises only when the second set is committed. byte_cnt_o shows the oldest set, and after a release it shows the next set.
- R8: When the held bytes (committed plus in-progress) fill all DEPTH locations, full_o is 1 and further writes are dropped with overflow_o. A set of DEPTH bytes can still be committed.
- R9: empty_o is 1 once every byte of the current set has been read. A rd_en_i while empty_o is 1 returns nothing (rd_valid_o stays 0).
- R10: rd_rewind_i returns the read position to the first byte of the current set, so the set can be read again. byte_cnt_o is unchanged.
- R11: rd_release_i frees the current set, and byte_cnt_o moves to the next set or to 0. A release with no committed set has no effect.
- R12: If a commit and a rollback arrive in the same cycle, the rollback wins. A byte offered in a cycle with a commit or a rollback is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we_i | input | 1 | Control register write enable |
| ctrl_wdata_i | input | 3 | Control value: bit0 single-set, bit1 auto commit, bit2 auto rollback |
| ctrl_o | output | 3 | Current control register value |
| wr_valid_i | input | 1 | Writer byte strobe |
| wr_data_i | input | DATA_W | Writer byte |
| eop_good_i | input | 1 | Packet ended without error |
| eop_bad_i | input | 1 | Packet ended with error |
| fw_commit_i | input | 1 | Firmware commit command |
| fw_rollback_i | input | 1 | Firmware rollback command |
| rd_en_i | input | 1 | CPU read request |
| rd_rewind_i | input | 1 | Restart reading the current set |
| rd_release_i | input | 1 | Free the current set |
| rd_data_o | output | DATA_W | Read byte, registered |
| rd_valid_o | output | 1 | rd_data_o holds a byte from the previous cycle's read |
| full_o | output | 1 | Writer must not write |
| empty_o | output | 1 | No unread committed byte in the current set |
| byte_cnt_o | output | ADDR_W+1 | Length of the current set |
| overflow_o | output | 1 | A write was dropped in the previous cycle |

## Verification
The embedded assertions watch the pointer relations on every cycle. After a commit the marker equals the old write pointer, and after a rollback the write pointer equals the old marker. Occupancy never exceeds DEPTH, the set count never exceeds two, and the read offset stays inside the current set. A release advances the read base by exactly the freed length, and read data never appears without an accepted request. Byte order, what the CPU actually sees for each control setting, the handover between two resident sets, simultaneous commit and rollback, and the reread path can only be shown by the bench's scenarios at the ports.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef struct packed {
    logic auto_rb;
    logic auto_cm;
    logic single;
  } rxf_ctrl_t;

  localparam rxf_ctrl_t CTRL_RESET = '{auto_rb: 1'b1, auto_cm: 1'b1, single: 1'b1};

  typedef enum logic [1:0] {
    PTR_HOLD     = 2'd0,
    PTR_ADV      = 2'd1,
    PTR_COMMIT   = 2'd2,
    PTR_ROLLBACK = 2'd3
  } wr_act_e;
endpackage

// File: rtl/rxf_ram.sv
module rxf_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/rxf_wr_side.sv
module rxf_wr_side
  import rxf_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int PTR_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  rxf_ctrl_t         ctrl_i,
  input  logic              wr_valid_i,
  input  logic              eop_good_i,
  input  logic              eop_bad_i,
  input  logic              fw_commit_i,
  input  logic              fw_rollback_i,
  input  logic [1:0]        set_cnt_i,
  input  logic [PTR_W-1:0]  rd_base_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic              push_o,
  output logic [PTR_W-1:0]  push_len_o,
  output logic              full_o,
  output logic              overflow_o
);
  logic [PTR_W-1:0] wr_ptr_q, marker_q, occ;
  logic [1:0]       set_limit;
  logic             set_full, rollback, commit_req;
  wr_act_e          act;

  assign set_limit  = ctrl_i.single ? 2'd1 : 2'd2;
  assign set_full   = (set_cnt_i >= set_limit);
  assign occ        = wr_ptr_q - rd_base_i;
  assign full_o     = set_full || (occ == PTR_W'(DEPTH));
  assign rollback   = fw_rollback_i | (eop_bad_i & ctrl_i.auto_rb);
  assign commit_req = fw_commit_i | (eop_good_i & ctrl_i.auto_cm);

  always_comb begin
    if (rollback)                    act = PTR_ROLLBACK;
    else if (commit_req)             act = set_full ? PTR_HOLD : PTR_COMMIT;
    else if (wr_valid_i && !full_o)  act = PTR_ADV;
    else                             act = PTR_HOLD;
  end

  assign mem_we_o    = (act == PTR_ADV);
  assign mem_waddr_o = wr_ptr_q[ADDR_W-1:0];
  assign push_o      = (act == PTR_COMMIT);
  assign push_len_o  = wr_ptr_q - marker_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q   <= '0;
      marker_q   <= '0;
      overflow_o <= 1'b0;
    end else begin
      overflow_o <= wr_valid_i && full_o;
      case (act)
        PTR_ADV:      wr_ptr_q <= wr_ptr_q + 1'b1;
        PTR_COMMIT:   marker_q <= wr_ptr_q;
        PTR_ROLLBACK: wr_ptr_q <= marker_q;
        default:      ;
      endcase
    end
  end

  // R3
  commit_moves_marker_chk: assert property (@(posedge clk) disable iff (rst)
    push_o |=> (marker_q == $past(wr_ptr_q)));

  // R4
  rollback_restores_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    (act == PTR_ROLLBACK) |=> (wr_ptr_q == $past(marker_q)));

  // R8
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr_q - rd_base_i) <= PTR_W'(DEPTH));

  // R6
  no_wr_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    (full_o && !rollback) |=> (wr_ptr_q == $past(wr_ptr_q)));
endmodule

// File: rtl/rxf_set_queue.sv
module rxf_set_queue #(
  parameter int ADDR_W = 4,
  localparam int PTR_W = ADDR_W + 1,
  localparam int SLOTS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [PTR_W-1:0]  push_len_i,
  input  logic              pop_i,
  input  logic              rewind_i,
  input  logic              rd_req_i,
  output logic [1:0]        set_cnt_o,
  output logic [PTR_W-1:0]  rd_base_o,
  output logic [PTR_W-1:0]  head_len_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_accept_o,
  output logic              empty_o
);
  logic [PTR_W-1:0] len_q [SLOTS];
  logic [PTR_W-1:0] rd_off_q, rd_base_q, rd_pos;
  logic [1:0]       set_cnt_q;
  logic             pop_ok;
  logic             push_idx;

  assign pop_ok      = pop_i && (set_cnt_q != 2'd0);
  assign push_idx    = set_cnt_q[0] ^ pop_ok;
  assign empty_o     = (set_cnt_q == 2'd0) || (rd_off_q == len_q[0]);
  assign rd_accept_o = rd_req_i && !empty_o && !pop_i && !rewind_i;
  assign rd_pos      = rd_base_q + rd_off_q;
  assign rd_addr_o   = rd_pos[ADDR_W-1:0];
  assign head_len_o  = (set_cnt_q != 2'd0) ? len_q[0] : '0;
  assign set_cnt_o   = set_cnt_q;
  assign rd_base_o   = rd_base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SLOTS; s++) len_q[s] <= '0;
      rd_off_q  <= '0;
      rd_base_q <= '0;
      set_cnt_q <= 2'd0;
    end else begin
      if (pop_ok) begin
        for (int s = 0; s < SLOTS - 1; s++) len_q[s] <= len_q[s+1];
        rd_base_q <= rd_base_q + len_q[0];
        rd_off_q  <= '0;
      end else if (rewind_i) begin
        rd_off_q <= '0;
      end else if (rd_accept_o) begin
        rd_off_q <= rd_off_q + 1'b1;
      end
      if (push_i) len_q[push_idx] <= push_len_i;
      set_cnt_q <= set_cnt_q + {1'b0, push_i} - {1'b0, pop_ok};
    end
  end

  // R7
  set_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    set_cnt_q <= 2'd2);

  // R9
  rd_off_in_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set_cnt_q != 2'd0) |-> (rd_off_q <= len_q[0]));

  // R11
  release_advances_base_chk: assert property (@(posedge clk) disable iff (rst)
    pop_ok |=> (rd_base_q == $past(rd_base_q + len_q[0])));

  // R10
  rewind_zeroes_off_chk: assert property (@(posedge clk) disable iff (rst)
    (rewind_i && !pop_i) |=> (rd_off_q == '0));
endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we_i,
  input  logic [2:0]        ctrl_wdata_i,
  output logic [2:0]        ctrl_o,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              eop_good_i,
  input  logic              eop_bad_i,
  input  logic              fw_commit_i,
  input  logic              fw_rollback_i,
  input  logic              rd_en_i,
  input  logic              rd_rewind_i,
  input  logic              rd_release_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [PTR_W-1:0]  byte_cnt_o,
  output logic              overflow_o
);
  rxf_ctrl_t         ctrl_q;
  logic              mem_we, push, rd_accept;
  logic [ADDR_W-1:0] mem_waddr, rd_addr;
  logic [PTR_W-1:0]  push_len, rd_base;
  logic [1:0]        set_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= CTRL_RESET;
      rd_valid_o <= 1'b0;
    end else begin
      if (ctrl_we_i) ctrl_q <= rxf_ctrl_t'(ctrl_wdata_i);
      rd_valid_o <= rd_accept;
    end
  end

  assign ctrl_o = ctrl_q;

  rxf_wr_side #(.ADDR_W(ADDR_W)) wr_i (
    .clk           (clk),
    .rst           (rst),
    .ctrl_i        (ctrl_q),
    .wr_valid_i    (wr_valid_i),
    .eop_good_i    (eop_good_i),
    .eop_bad_i     (eop_bad_i),
    .fw_commit_i   (fw_commit_i),
    .fw_rollback_i (fw_rollback_i),
    .set_cnt_i     (set_cnt),
    .rd_base_i     (rd_base),
    .mem_we_o      (mem_we),
    .mem_waddr_o   (mem_waddr),
    .push_o        (push),
    .push_len_o    (push_len),
    .full_o        (full_o),
    .overflow_o    (overflow_o)
  );

  rxf_set_queue #(.ADDR_W(ADDR_W)) sq_i (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push),
    .push_len_i  (push_len),
    .pop_i       (rd_release_i),
    .rewind_i    (rd_rewind_i),
    .rd_req_i    (rd_en_i),
    .set_cnt_o   (set_cnt),
    .rd_base_o   (rd_base),
    .head_len_o  (byte_cnt_o),
    .rd_addr_o   (rd_addr),
    .rd_accept_o (rd_accept),
    .empty_o     (empty_o)
  );

  rxf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
    .clk     (clk),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (wr_data_i),
    .re_i    (rd_accept),
    .raddr_i (rd_addr),
    .rdata_o (rd_data_o)
  );

  // R2
  rd_valid_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(rd_accept));
endmodule

// File: tb/pkt_rx_fifo_tb.sv
module pkt_rx_fifo_tb_top;
  localparam int CLK_P = 10;
  localparam int VW = 20;
  // {wr, eop_good, eop_bad, release, data[7:0], exp_empty, exp_full, exp_ovf, exp_cnt[4:0]}
  localparam logic [VW-1:0] VEC [11] = '{
    {1'b1,1'b0,1'b0,1'b0,8'hA0,1'b1,1'b0,1'b0,5'd0},
    {1'b1,1'b0,1'b0,1'b0,8'hA1,1'b1,1'b0,1'b0,5'd0},
    {1'b1,1'b0,1'b0,1'b0,8'hA2,1'b1,1'b0,1'b0,5'd0},
    {1'b0,1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,5'd3},
    {1'b1,1'b0,1'b0,1'b0,8'hB0,1'b0,1'b1,1'b1,5'd3},
    {1'b0,1'b0,1'b0,1'b1,8'h00,1'b1,1'b0,1'b0,5'd0},
    {1'b1,1'b0,1'b0,1'b0,8'hC0,1'b1,1'b0,1'b0,5'd0},
    {1'b0,1'b0,1'b1,1'b0,8'h00,1'b1,1'b0,1'b0,5'd0},
    {1'b1,1'b0,1'b0,1'b0,8'hC1,1'b1,1'b0,1'b0,5'd0},
    {1'b0,1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,5'd1},
    {1'b0,1'b0,1'b0,1'b1,8'h00,1'b1,1'b0,1'b0,5'd0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic ctrl_we, wr_valid, eop_good, eop_bad, fw_commit, fw_rollback;
  logic rd_en, rd_rewind, rd_release;
  logic [2:0] ctrl_wdata, ctrl_o;
  logic [7:0] wr_data, rd_data;
  logic rd_valid, full, empty, overflow;
  logic [4:0] byte_cnt;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  pkt_rx_fifo dut_i (
    .clk(clk), .rst(rst), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_o(ctrl_o),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .eop_good_i(eop_good), .eop_bad_i(eop_bad),
    .fw_commit_i(fw_commit), .fw_rollback_i(fw_rollback), .rd_en_i(rd_en),
    .rd_rewind_i(rd_rewind), .rd_release_i(rd_release), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .full_o(full), .empty_o(empty), .byte_cnt_o(byte_cnt),
    .overflow_o(overflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ctrl_we = 0; ctrl_wdata = 0; wr_valid = 0; wr_data = 0; eop_good = 0; eop_bad = 0;
    fw_commit = 0; fw_rollback = 0; rd_en = 0; rd_rewind = 0; rd_release = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic wr(input logic [7:0] b); wr_valid = 1; wr_data = b; tick(); endtask
  task automatic good(); eop_good = 1; tick(); endtask
  task automatic bad(); eop_bad = 1; tick(); endtask
  task automatic rd(); rd_en = 1; tick(); endtask
  task automatic rel(); rd_release = 1; tick(); endtask
  task automatic set_ctrl(input logic [2:0] v); ctrl_we = 1; ctrl_wdata = v; tick(); endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 ctrl", ctrl_o, 3'b111);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 cnt", byte_cnt, 0);
    chk("R1 ovf", overflow, 0);

    // Vector walk: R3 commit, R6 single-set refusal, R4 rollback, R11 release
    for (int i = 0; i < 11; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      wr_valid = v[19]; eop_good = v[18]; eop_bad = v[17]; rd_release = v[16]; wr_data = v[15:8];
      tick();
      chk("R3/R4/R6/R11 vec empty", empty, v[7]);
      chk("R3/R4/R6/R11 vec full", full, v[6]);
      chk("R6 vec overflow", overflow, v[5]);
      chk("R3/R4 vec cnt", byte_cnt, v[4:0]);
    end

    // R2 order and invisibility of uncommitted bytes
    wr(8'h11); wr(8'h22); wr(8'h33);
    chk("R2 uncommitted hidden", empty, 1);
    good();
    chk("R3 cnt", byte_cnt, 3);
    rd(); chk("R2 valid", rd_valid, 1); chk("R2 byte0", rd_data, 8'h11);
    rd(); chk("R2 byte1", rd_data, 8'h22);
    rd(); chk("R2 byte2", rd_data, 8'h33);
    chk("R9 empty after set", empty, 1);
    rd(); chk("R9 read while empty", rd_valid, 0);
    rd_rewind = 1; tick();
    chk("R10 not empty", empty, 0);
    rd(); chk("R10 reread", rd_data, 8'h11);
    chk("R10 cnt kept", byte_cnt, 3);
    rel();
    chk("R11 cnt", byte_cnt, 0);
    rel();
    chk("R11 empty release", byte_cnt, 0);
    chk("R11 empty flag", empty, 1);

    // R5 firmware-driven commit and rollback
    set_ctrl(3'b001);
    wr(8'h44); wr(8'h55);
    good();
    chk("R5 good ignored", empty, 1);
    bad();
    fw_commit = 1; tick();
    chk("R5 bad ignored", byte_cnt, 2);
    rel();
    wr(8'h66);
    fw_rollback = 1; tick();
    wr(8'h77);
    fw_commit = 1; tick();
    chk("R5 fw cnt", byte_cnt, 1);
    rd(); chk("R5 fw data", rd_data, 8'h77);
    rel();

    // R7 dual-set mode
    set_ctrl(3'b110);
    wr(8'h01); wr(8'h02); good();
    chk("R7 second allowed", full, 0);
    wr(8'h03); wr(8'h04); wr(8'h05); good();
    chk("R7 full two sets", full, 1);
    chk("R7 head cnt", byte_cnt, 2);
    rd(); chk("R7 head b0", rd_data, 8'h01);
    rd(); chk("R7 head b1", rd_data, 8'h02);
    rel();
    chk("R7 next cnt", byte_cnt, 3);
    rd(); chk("R7 next b0", rd_data, 8'h03);
    rel();
    chk("R7 drained", empty, 1);

    // R8 occupancy full
    for (int k = 0; k < 16; k++) wr(8'h80 + 8'(k));
    chk("R8 full", full, 1);
    wr(8'hFF);
    chk("R8 overflow", overflow, 1);
    good();
    chk("R8 cnt", byte_cnt, 16);
    rd(); chk("R8 first", rd_data, 8'h80);
    rel();

    // R12 rollback beats commit
    wr(8'hAA);
    eop_good = 1; eop_bad = 1; tick();
    chk("R12 nothing committed", empty, 1);
    chk("R12 cnt", byte_cnt, 0);
    wr(8'hBB); good();
    chk("R12 cnt after retry", byte_cnt, 1);
    rd(); chk("R12 data", rd_data, 8'hBB);
    rel();

    // R6 directed refusal in single-set mode
    set_ctrl(3'b111);
    wr(8'h05); good();
    wr(8'h06);
    chk("R6 full", full, 1);
    chk("R6 overflow", overflow, 1);
    rel();
    wr(8'h07); good();
    rd(); chk("R6 dropped byte absent", rd_data, 8'h07);

    finish_run();
  end
endmodule